// File: doc/BRIEF.md
# Condition Flag Register and Conditional Branch Unit

This block keeps the four condition flags of a small 8-bit processor and decides where the instruction stream goes after a conditional jump. When an arithmetic or logic instruction finishes, the block derives the flags from the operands and result that the ALU presents. It derives Carry from the adder carry-out, A larger from comparing the bus-side operand with the held temporary operand, Equal from the same comparison, and Zero from the 8-bit result. A dedicated clear opcode resets all four flags.

A conditional jump carries a 4-bit mask in its low nibble. The jump is taken when any flag selected by the mask is set, so a mask with several bits set gives the OR of the selected conditions. The block owns the instruction-address register. For a jump it reads the byte that follows the opcode through a simple one-cycle-latency memory read port. It then loads that byte into the address register when the jump is taken, or steps past it when it is not. Every instruction ends with a one-cycle completion strobe that also reports whether a branch was taken.

The reset input is asynchronous and active low. It is released through a two-stage synchronizer inside the block. A new instruction is offered only while the block is idle: not between a jump's opcode and its completion strobe.

Top module: `flagbr_top`

## Requirements
- R1: While reset is held and after it is released, flags are 0000, the instruction address is 0, and done, taken and mem_rd are 0.
- R2: An instruction whose opcode bit 7 is 1 is an ALU instruction. It overwrites all four flags, with flags[3]=Carry, flags[2]=A larger, flags[1]=Equal and flags[0]=Zero. Carry equals alu_cout and Zero is set exactly when alu_result is 0x00. The instruction also advances the instruction address by 1.
- R3: A larger is set only when alu_bus is greater than alu_tmp, so comparing a register held in tmp against a register on the bus flags the bus-side one as larger. Equal is set when alu_bus equals alu_tmp, and then A larger is clear.
- R4: Opcode 0x60 clears all four flags, advances the instruction address by 1, and changes nothing else.
- R5: An opcode with upper nibble 0101 is a conditional jump. In the cycle after it is accepted, mem_rd is high for exactly one cycle and mem_addr equals the opcode's address plus 1.
- R6: A jump is taken when (mask AND flags) is nonzero, with the mask bits in the same positions as the flag bits. When it is taken, the instruction address becomes the byte returned on mem_rdata and taken is 1 with done.
- R7: A jump that is not taken, including any jump with mask 0000, sets the instruction address to the opcode's address plus 2, and taken is 0.
- R8: A mask with several bits set branches when any one of the selected flags is set, and does not branch when none of them is set.
- R9: Flags hold their value through jumps and through opcodes that are neither ALU instructions nor 0x60. Such other opcodes advance the instruction address by 1.
- R10: done is high for one cycle per instruction. For ALU, clear and other opcodes it is high in the cycle after the start edge. For a jump it is high two cycles later than that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Offer the instruction on opcode (sampled while idle) |
| opcode | input | 8 | Opcode of the instruction at the current address |
| alu_bus | input | DW | Bus-side ALU operand |
| alu_tmp | input | DW | Held temporary ALU operand |
| alu_result | input | DW | ALU result |
| alu_cout | input | 1 | Carry-out of the ALU add |
| mem_rdata | input | AW | Byte read from memory, valid one cycle after mem_rd |
| mem_rd | output | 1 | Memory read request for the jump target byte |
| mem_addr | output | AW | Memory read address |
| iar | output | AW | Instruction-address register |
| flags | output | 4 | Carry, A larger, Equal, Zero (bits 3 to 0) |
| done | output | 1 | One-cycle instruction completion strobe |
| taken | output | 1 | High with done when a jump branched |

## Verification
The assertions watch every cycle for several properties. They check that flags change only on an accepted instruction, that the Zero and A larger bits follow the ALU inputs of the accepted instruction, and that the clear opcode zeros the flags. They also check that Equal and A larger are never set together, that each target read lasts one cycle, and that a taken jump loads exactly the byte the memory returned. Only the bench's scenarios can show three things: the mask-to-flag correspondence for single-bit and multi-bit masks, the step of two past a jump that is not taken, and the latency of done for each class of instruction.

// File: rtl/flagbr_pkg.sv
package flagbr_pkg;

  typedef struct packed {
    logic carry;
    logic alarger;
    logic equal;
    logic zero;
  } flags_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WAIT = 2'd2
  } state_t;

  typedef enum logic [1:0] {
    CLS_OTHER = 2'd0,
    CLS_ALU   = 2'd1,
    CLS_CLR   = 2'd2,
    CLS_JUMP  = 2'd3
  } op_class_t;

  localparam logic [3:0] OPHI_JUMP = 4'b0101;
  localparam logic [7:0] OP_CLR    = 8'h60;

  function automatic op_class_t classify(input logic [7:0] op);
    if (op[7])                    return CLS_ALU;
    else if (op == OP_CLR)        return CLS_CLR;
    else if (op[7:4] == OPHI_JUMP) return CLS_JUMP;
    else                          return CLS_OTHER;
  endfunction

endpackage

// File: rtl/flagbr_rst_sync.sv
module flagbr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/flagbr_flag_gen.sv
module flagbr_flag_gen
  import flagbr_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [DW-1:0] bus_val,
  input  logic [DW-1:0] tmp_val,
  input  logic [DW-1:0] result,
  input  logic          cout,
  output flags_t        flags_new
);

  always_comb begin
    flags_new.carry   = cout;
    flags_new.alarger = (bus_val > tmp_val);
    flags_new.equal   = (bus_val == tmp_val);
    flags_new.zero    = (result == '0);
  end

endmodule

// File: rtl/flagbr_cond.sv
module flagbr_cond #(
  parameter int NF = 4
) (
  input  logic [NF-1:0] mask,
  input  logic [NF-1:0] flag_bits,
  output logic          hit
);

  logic [NF-1:0] sel;

  for (genvar g = 0; g < NF; g++) begin : g_sel
    assign sel[g] = mask[g] & flag_bits[g];
  end

  assign hit = |sel;

endmodule

// File: rtl/flagbr_top.sv
module flagbr_top
  import flagbr_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [7:0]    opcode,
  input  logic [DW-1:0] alu_bus,
  input  logic [DW-1:0] alu_tmp,
  input  logic [DW-1:0] alu_result,
  input  logic          alu_cout,
  input  logic [AW-1:0] mem_rdata,
  output logic          mem_rd,
  output logic [AW-1:0] mem_addr,
  output logic [AW-1:0] iar,
  output logic [3:0]    flags,
  output logic          done,
  output logic          taken
);

  localparam int NF = $bits(flags_t);
  localparam logic [AW-1:0] STEP1 = AW'(1);
  localparam logic [AW-1:0] STEP2 = AW'(2);

  logic      rst_i_n;
  state_t    state_q, state_d;
  flags_t    flags_q, flags_d, flags_alu;
  logic      flags_en;
  logic [AW-1:0] iar_q, iar_d;
  logic      iar_en;
  logic [NF-1:0] mask_q, mask_d;
  logic      mask_en;
  logic      done_q, done_d, taken_q, taken_d;
  logic      cond_hit;
  logic      idle;
  op_class_t cls;

  flagbr_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  flagbr_flag_gen #(.DW(DW)) u_gen (
    .bus_val   (alu_bus),
    .tmp_val   (alu_tmp),
    .result    (alu_result),
    .cout      (alu_cout),
    .flags_new (flags_alu)
  );

  flagbr_cond #(.NF(NF)) u_cond (
    .mask      (mask_q),
    .flag_bits (flags_q),
    .hit       (cond_hit)
  );

  assign cls  = classify(opcode);
  assign idle = (state_q == ST_IDLE);

  always_comb begin
    state_d  = state_q;
    flags_d  = flags_q;
    flags_en = 1'b0;
    iar_d    = iar_q;
    iar_en   = 1'b0;
    mask_d   = mask_q;
    mask_en  = 1'b0;
    done_d   = 1'b0;
    taken_d  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          unique case (cls)
            CLS_ALU: begin
              flags_d  = flags_alu;
              flags_en = 1'b1;
              iar_d    = iar_q + STEP1;
              iar_en   = 1'b1;
              done_d   = 1'b1;
            end
            CLS_CLR: begin
              flags_d  = '0;
              flags_en = 1'b1;
              iar_d    = iar_q + STEP1;
              iar_en   = 1'b1;
              done_d   = 1'b1;
            end
            CLS_JUMP: begin
              mask_d  = opcode[NF-1:0];
              mask_en = 1'b1;
              state_d = ST_RD;
            end
            default: begin
              iar_d  = iar_q + STEP1;
              iar_en = 1'b1;
              done_d = 1'b1;
            end
          endcase
        end
      end
      ST_RD: state_d = ST_WAIT;
      ST_WAIT: begin
        taken_d = cond_hit;
        iar_d   = cond_hit ? mem_rdata : (iar_q + STEP2);
        iar_en  = 1'b1;
        done_d  = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      state_q <= ST_IDLE;
      flags_q <= '0;
      iar_q   <= '0;
      mask_q  <= '0;
      done_q  <= 1'b0;
      taken_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (flags_en) flags_q <= flags_d;
      if (iar_en)   iar_q   <= iar_d;
      if (mask_en)  mask_q  <= mask_d;
      done_q  <= done_d;
      taken_q <= taken_d;
    end
  end

  assign mem_rd   = (state_q == ST_RD);
  assign mem_addr = iar_q + STEP1;
  assign iar      = iar_q;
  assign flags    = flags_q;
  assign done     = done_q;
  assign taken    = taken_q;

endmodule

// File: rtl/flagbr_chk.sv
module flagbr_chk #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          idle,
  input logic [7:0]    opcode,
  input logic [DW-1:0] alu_bus,
  input logic [DW-1:0] alu_tmp,
  input logic [DW-1:0] alu_result,
  input logic [AW-1:0] mem_rdata,
  input logic          mem_rd,
  input logic [AW-1:0] iar,
  input logic [3:0]    flags,
  input logic          done,
  input logic          taken
);

  // R2: Zero follows the result of the accepted ALU instruction
  a_r2_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (start && idle && opcode[7]) |=> (flags[0] == ($past(alu_result) == '0)));

  // R3: A larger means bus operand exceeds tmp operand
  a_r3_alarger_sense: assert property (@(posedge clk) disable iff (!rst_n)
    (start && idle && opcode[7]) |=> (flags[2] == ($past(alu_bus) > $past(alu_tmp))));

  // R3: Equal and A larger are never set together
  a_r3_equal_excludes: assert property (@(posedge clk) disable iff (!rst_n)
    flags[1] |-> !flags[2]);

  // R4: clear opcode zeros the flags
  a_r4_clear_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (start && idle && opcode == 8'h60) |=> (flags == 4'b0000));

  // R9: flags move only on an accepted instruction
  a_r9_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(start && idle) |=> $stable(flags));

  // R5: the target read lasts one cycle
  a_r5_single_read: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> !mem_rd);

  // R6: a taken jump loads the byte returned by memory
  a_r6_target_load: assert property (@(posedge clk) disable iff (!rst_n)
    (done && taken) |-> (iar == $past(mem_rdata)));

  // R10: taken is reported only with done
  a_r10_taken_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    taken |-> done);

endmodule

bind flagbr_top flagbr_chk #(.AW(AW), .DW(DW)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .idle       (idle),
  .opcode     (opcode),
  .alu_bus    (alu_bus),
  .alu_tmp    (alu_tmp),
  .alu_result (alu_result),
  .mem_rdata  (mem_rdata),
  .mem_rd     (mem_rd),
  .iar        (iar),
  .flags      (flags),
  .done       (done),
  .taken      (taken)
);

// File: tb/flagbr_top_tb_top.sv
module flagbr_top_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int DW = 8;

  logic          clk;
  logic          rst_n;
  logic          start;
  logic [7:0]    opcode;
  logic [DW-1:0] alu_bus, alu_tmp, alu_result;
  logic          alu_cout;
  logic [AW-1:0] mem_rdata;
  logic          mem_rd;
  logic [AW-1:0] mem_addr;
  logic [AW-1:0] iar;
  logic [3:0]    flags;
  logic          done;
  logic          taken;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 0;

  logic [AW-1:0] exp_iar;
  logic [3:0]    exp_flags;

  flagbr_top #(.AW(AW), .DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
    .alu_bus(alu_bus), .alu_tmp(alu_tmp), .alu_result(alu_result),
    .alu_cout(alu_cout), .mem_rdata(mem_rdata), .mem_rd(mem_rd),
    .mem_addr(mem_addr), .iar(iar), .flags(flags), .done(done),
    .taken(taken)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [AW-1:0] target_of(input logic [AW-1:0] a);
    return a * AW'(5) + AW'(17);
  endfunction

  initial mem_rdata = '0;
  always @(posedge clk) if (mem_rd) mem_rdata <= target_of(mem_addr);

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic do_single(input logic [7:0] op, input logic [7:0] bus,
                           input logic [7:0] tmp, input logic [7:0] res,
                           input logic cout, input string req);
    @(negedge clk);
    start = 1'b1; opcode = op;
    alu_bus = bus; alu_tmp = tmp; alu_result = res; alu_cout = cout;
    @(negedge clk);
    start = 1'b0;
    if (op[7])
      exp_flags = {cout, bus > tmp, bus == tmp, res == 8'h00};
    else if (op == 8'h60)
      exp_flags = 4'b0000;
    exp_iar = exp_iar + 1'b1;
    check(req, "flags", {28'd0, flags}, {28'd0, exp_flags});
    check(req, "iar", {24'd0, iar}, {24'd0, exp_iar});
    check("R10", "done after single", {31'd0, done}, 32'd1);
    check("R10", "taken on single", {31'd0, taken}, 32'd0);
    @(negedge clk);
    check("R10", "done pulse width", {31'd0, done}, 32'd0);
  endtask

  task automatic do_jump(input logic [3:0] mask, input string req);
    logic exp_taken;
    @(negedge clk);
    start = 1'b1; opcode = {4'b0101, mask};
    alu_bus = 8'hAA; alu_tmp = 8'h01; alu_result = 8'h00; alu_cout = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R5", "mem_rd", {31'd0, mem_rd}, 32'd1);
    check("R5", "mem_addr", {24'd0, mem_addr}, {24'd0, exp_iar + 8'd1});
    check("R10", "no early done", {31'd0, done}, 32'd0);
    @(negedge clk);
    check("R5", "mem_rd one cycle", {31'd0, mem_rd}, 32'd0);
    check("R10", "no early done", {31'd0, done}, 32'd0);
    @(negedge clk);
    exp_taken = |(mask & exp_flags);
    exp_iar = exp_taken ? target_of(exp_iar + 8'd1) : exp_iar + 8'd2;
    check("R10", "done after jump", {31'd0, done}, 32'd1);
    check(req, "taken", {31'd0, taken}, {31'd0, exp_taken});
    check(req, "iar", {24'd0, iar}, {24'd0, exp_iar});
    check("R9", "flags held over jump", {28'd0, flags}, {28'd0, exp_flags});
    @(negedge clk);
    check("R10", "done pulse width", {31'd0, done}, 32'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; opcode = 8'h00;
    alu_bus = '0; alu_tmp = '0; alu_result = '0; alu_cout = 1'b0;
    exp_iar = '0; exp_flags = 4'b0000;
    repeat (3) @(negedge clk);
    check("R1", "flags in reset", {28'd0, flags}, 32'd0);
    check("R1", "iar in reset", {24'd0, iar}, 32'd0);
    check("R1", "done in reset", {31'd0, done}, 32'd0);
    check("R1", "mem_rd in reset", {31'd0, mem_rd}, 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", "flags after reset", {28'd0, flags}, 32'd0);
    check("R1", "iar after reset", {24'd0, iar}, 32'd0);
    check("R1", "taken after reset", {31'd0, taken}, 32'd0);

    do_single(8'h81, 8'd7, 8'd4, 8'h0B, 1'b0, "R3");   // bus larger -> 0100
    do_jump(4'b0100, "R6");                           // A larger taken
    do_jump(4'b0000, "R7");                           // empty mask never
    do_single(8'h90, 8'd4, 8'd7, 8'hFD, 1'b1, "R2");  // carry only -> 1000
    do_jump(4'b0100, "R7");                           // A larger clear
    do_jump(4'b1000, "R6");                           // carry taken
    do_single(8'hA2, 8'd5, 8'd5, 8'h00, 1'b0, "R3");  // equal -> 0011
    do_single(8'h20, 8'd9, 8'd1, 8'h00, 1'b1, "R9");  // other opcode holds
    do_jump(4'b0011, "R8");                           // equal or zero
    do_jump(4'b1100, "R8");                           // carry or larger: none
    do_single(8'h60, 8'd9, 8'd1, 8'h00, 1'b1, "R4");  // clear
    do_jump(4'b1111, "R7");                           // all masked, no flags
    do_single(8'hFF, 8'd0, 8'd0, 8'h00, 1'b1, "R2");  // 1011
    do_jump(4'b1111, "R8");                           // any set
    do_jump(4'b0100, "R7");                           // larger clear on equal

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule